// File: doc/BRIEF.md
# Dual High-Side Switch Protection Controller

This block is the digital sequencer that sits between a control input and the gate drivers of a two-channel high-side switch. Two local enable bits pick which channels follow the common control input. Channel 2 follows its request directly. Channel 1 runs a timed leakage self-test before each turn-on and then watches an over-current comparator. If the over-current persists, channel 1 latches off.

A sustained overvoltage on the drain line forces channel 2 on for a fixed pulse, whatever the control input says. The control input and the three analog comparator flags (over-current, drain overvoltage, leakage-test result) are asynchronous. Each passes through a two-flop synchronizer. All timing windows are parameters counted in clock cycles.

Top module: `hs_switch_guard`

## Requirements
- R1: When the control input is low, both gate enables are off within four clock cycles. The one exception is a channel 2 overvoltage pulse.
- R2: Each new channel 1 request drives the leakage-test enable high for exactly LEAK_CYC cycles. The channel 1 gate stays low throughout that window.
- R3: Channel 1 turns on in the cycle after the test window ends, but only if the synchronized leakage result is high in the last test cycle. Otherwise channel 1 stays off and status bit 1 (leakage failure) is set until the request is withdrawn.
- R4: While channel 1 is on, the over-current flag must be high for OC_DET_CYC consecutive synchronized cycles to trip it. A shorter burst resets the count and has no effect.
- R5: An over-current trip turns channel 1 off and sets status bit 0 (over-current latched). Channel 1 then stays off, even with the flag gone, until the control input goes low and then high again. The high level starts a fresh leakage test.
- R6: The overvoltage flag must be high for OV_DET_CYC consecutive synchronized cycles. Channel 2 is then driven on for exactly OV_ACT_CYC cycles, and status bit 2 is high for the same span. A shorter overvoltage burst has no effect.
- R7: During an overvoltage pulse with the control input low, channel 1 stays off.
- R8: Three channel modes work: channel 1 alone, both channels together, and channel 2 added while channel 1 is already on without disturbing channel 1.
- R9: An asynchronous input change reaches the sequencer two cycles after it is sampled. A channel 1 request first raises the leakage-test enable at the third clock edge after the control input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlIn | input | 1 | Asynchronous control input level, high = on |
| ch1En | input | 1 | Local enable for channel 1 (synchronous) |
| ch2En | input | 1 | Local enable for channel 2 (synchronous) |
| ocFlagIn | input | 1 | Asynchronous channel 1 over-current comparator flag |
| ovFlagIn | input | 1 | Asynchronous drain overvoltage flag |
| leakOkIn | input | 1 | Asynchronous leakage-test result, high = pass |
| gate1 | output | 1 | Channel 1 gate enable |
| gate2 | output | 1 | Channel 2 gate enable |
| leakTestEn | output | 1 | Leakage-test current enable |
| status | output | 3 | bit0 over-current latched, bit1 leakage failure, bit2 overvoltage pulse active |

## Verification
The bench measures the first cycle of the leakage window, its length and the cycle in which channel 1 turns on. A design with an off-by-one counter or a missing synchronizer stage shifts these numbers. Over-current and overvoltage bursts one cycle shorter than the detection time must change nothing. A timer that did not restart would trip on them. After an over-current trip, the bench keeps the request high and checks that channel 1 stays latched; a latch that cleared on flag release would let the channel turn back on. The bench also counts the overvoltage pulse length with the control input low and checks that channel 1 stays off during it.

// File: rtl/hs_guard_pkg.sv
package hs_guard_pkg;

  typedef enum logic [2:0] {
    CH1_IDLE    = 3'd0,
    CH1_TEST    = 3'd1,
    CH1_ON      = 3'd2,
    CH1_OCLATCH = 3'd3,
    CH1_LKFAIL  = 3'd4
  } ch1State_t;

  // strobes from the sequencer to the timer datapath
  typedef struct packed {
    logic leakClr;
    logic leakRun;
    logic ocArm;
  } seqStrobes_t;

  // events from the timer datapath back to the sequencer
  typedef struct packed {
    logic leakDone;
    logic leakPass;
    logic ocTrip;
    logic ovPulse;
  } dpEvents_t;

endpackage

// File: rtl/hs_guard_sync.sv
module hs_guard_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/hs_guard_dp.sv
module hs_guard_dp
  import hs_guard_pkg::*;
#(
  parameter int LEAK_CYC   = 8,
  parameter int OC_DET_CYC = 6,
  parameter int OV_DET_CYC = 5,
  parameter int OV_ACT_CYC = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlRaw,
  input  logic        ocRaw,
  input  logic        ovRaw,
  input  logic        leakRaw,
  input  seqStrobes_t strobes,
  output logic        ctrlS,
  output dpEvents_t   events
);
  localparam int LEAK_W = $clog2(LEAK_CYC + 1);
  localparam int OC_W   = $clog2(OC_DET_CYC + 1);
  localparam int OVD_W  = $clog2(OV_DET_CYC + 1);
  localparam int OVA_W  = $clog2(OV_ACT_CYC + 1);
  localparam logic [LEAK_W-1:0] LEAK_LAST = LEAK_W'(LEAK_CYC - 1);
  localparam logic [OC_W-1:0]   OC_LAST   = OC_W'(OC_DET_CYC - 1);
  localparam logic [OVD_W-1:0]  OVD_LAST  = OVD_W'(OV_DET_CYC - 1);
  localparam logic [OVA_W-1:0]  OVA_LAST  = OVA_W'(OV_ACT_CYC - 1);

  logic ocS, ovS, leakS;
  logic [LEAK_W-1:0] leakCnt;
  logic [OC_W-1:0]   ocCnt;
  logic [OVD_W-1:0]  ovCnt;
  logic [OVA_W-1:0]  pulseCnt;
  logic              pulseOn;
  logic              ovQual;

  hs_guard_sync #(.WIDTH(4)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({ctrlRaw, ocRaw, ovRaw, leakRaw}),
    .syncOut ({ctrlS, ocS, ovS, leakS})
  );

  // leakage-test window timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 leakCnt <= '0;
    else if (strobes.leakClr)                  leakCnt <= '0;
    else if (strobes.leakRun && !events.leakDone) leakCnt <= leakCnt + 1'b1;
  end

  // over-current qualification: restarts whenever the flag drops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ocCnt <= '0;
    else if (!(strobes.ocArm && ocS))   ocCnt <= '0;
    else if (!events.ocTrip)            ocCnt <= ocCnt + 1'b1;
  end

  // overvoltage qualification: held clear while a pulse runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ovCnt <= '0;
    else if (!ovS || pulseOn)  ovCnt <= '0;
    else if (!ovQual)          ovCnt <= ovCnt + 1'b1;
  end

  assign ovQual = ovS && !pulseOn && (ovCnt == OVD_LAST);

  // channel 2 forced pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseOn  <= 1'b0;
      pulseCnt <= '0;
    end else if (ovQual) begin
      pulseOn  <= 1'b1;
      pulseCnt <= OVA_LAST;
    end else if (pulseOn) begin
      if (pulseCnt == '0) pulseOn <= 1'b0;
      else                pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    events.leakDone = strobes.leakRun && (leakCnt == LEAK_LAST);
    events.leakPass = leakS;
    events.ocTrip   = strobes.ocArm && ocS && (ocCnt == OC_LAST);
    events.ovPulse  = pulseOn;
  end
endmodule

// File: rtl/hs_guard_ctl.sv
module hs_guard_ctl
  import hs_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlS,
  input  logic        ch1En,
  input  dpEvents_t   events,
  output seqStrobes_t strobes,
  output logic        gate1,
  output logic        leakTestEn,
  output logic        ocLatched,
  output logic        leakFail
);
  ch1State_t state, stateNext;
  logic      req1;

  assign req1 = ctrlS && ch1En;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CH1_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      CH1_IDLE:    if (req1) stateNext = CH1_TEST;
      CH1_TEST: begin
        if (!req1)                stateNext = CH1_IDLE;
        else if (events.leakDone) stateNext = events.leakPass ? CH1_ON : CH1_LKFAIL;
      end
      CH1_ON: begin
        if (!req1)               stateNext = CH1_IDLE;
        else if (events.ocTrip)  stateNext = CH1_OCLATCH;
      end
      CH1_OCLATCH: if (!ctrlS) stateNext = CH1_IDLE;
      CH1_LKFAIL:  if (!req1)  stateNext = CH1_IDLE;
      default:     stateNext = CH1_IDLE;
    endcase
  end

  always_comb begin
    strobes.leakClr = (state != CH1_TEST);
    strobes.leakRun = (state == CH1_TEST);
    strobes.ocArm   = (state == CH1_ON);
  end

  assign gate1      = (state == CH1_ON);
  assign leakTestEn = (state == CH1_TEST);
  assign ocLatched  = (state == CH1_OCLATCH);
  assign leakFail   = (state == CH1_LKFAIL);
endmodule

// File: rtl/hs_switch_guard.sv
module hs_switch_guard
  import hs_guard_pkg::*;
#(
  parameter int LEAK_CYC   = 8,
  parameter int OC_DET_CYC = 6,
  parameter int OV_DET_CYC = 5,
  parameter int OV_ACT_CYC = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlIn,
  input  logic       ch1En,
  input  logic       ch2En,
  input  logic       ocFlagIn,
  input  logic       ovFlagIn,
  input  logic       leakOkIn,
  output logic       gate1,
  output logic       gate2,
  output logic       leakTestEn,
  output logic [2:0] status
);
  seqStrobes_t strobes;
  dpEvents_t   events;
  logic        ctrlS;
  logic        ocLatched, leakFail;

  hs_guard_dp #(
    .LEAK_CYC  (LEAK_CYC),
    .OC_DET_CYC(OC_DET_CYC),
    .OV_DET_CYC(OV_DET_CYC),
    .OV_ACT_CYC(OV_ACT_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlRaw (ctrlIn),
    .ocRaw   (ocFlagIn),
    .ovRaw   (ovFlagIn),
    .leakRaw (leakOkIn),
    .strobes (strobes),
    .ctrlS   (ctrlS),
    .events  (events)
  );

  hs_guard_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlS      (ctrlS),
    .ch1En      (ch1En),
    .events     (events),
    .strobes    (strobes),
    .gate1      (gate1),
    .leakTestEn (leakTestEn),
    .ocLatched  (ocLatched),
    .leakFail   (leakFail)
  );

  assign gate2  = (ctrlS && ch2En) || events.ovPulse;
  assign status = {events.ovPulse, leakFail, ocLatched};
endmodule

// File: rtl/hs_switch_guard_chk.sv
module hs_switch_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlIn,
  input logic       gate1,
  input logic       gate2,
  input logic       leakTestEn,
  input logic [2:0] status
);
  // R1: control low for long enough forces channel 1 off
  a_r1_gate1_off: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ctrlIn, 3) && !$past(ctrlIn, 4)) |-> !gate1);

  // R1: channel 2 off with control low unless an overvoltage pulse runs
  a_r1_gate2_off: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ctrlIn, 2) && !status[2]) |-> !gate2);

  // R2: channel 1 only turns on straight out of a leakage test
  a_r2_test_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gate1) |-> $past(leakTestEn));

  // R3: a failed leakage test cannot hand over to an on channel
  a_r3_fail_stays_off: assert property (@(posedge clk) disable iff (!rstN)
    status[1] |=> !gate1);

  // R5: an over-current latch never releases straight into on
  a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rstN)
    status[0] |=> !gate1);
endmodule

bind hs_switch_guard hs_switch_guard_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctrlIn     (ctrlIn),
  .gate1      (gate1),
  .gate2      (gate2),
  .leakTestEn (leakTestEn),
  .status     (status)
);

// File: tb/test_hs_switch_guard.sv
`timescale 1ns/1ps
module test_hs_switch_guard;
  localparam int LEAK = 8;
  localparam int OCD  = 6;
  localparam int OVD  = 5;
  localparam int OVA  = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlIn = 1'b0, ch1En = 1'b0, ch2En = 1'b0;
  logic ocFlagIn = 1'b0, ovFlagIn = 1'b0, leakOkIn = 1'b0;
  logic gate1, gate2, leakTestEn;
  logic [2:0] status;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  hs_switch_guard #(
    .LEAK_CYC(LEAK), .OC_DET_CYC(OCD), .OV_DET_CYC(OVD), .OV_ACT_CYC(OVA)
  ) i_hs_switch_guard (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlIn), .ch1En(ch1En), .ch2En(ch2En),
    .ocFlagIn(ocFlagIn), .ovFlagIn(ovFlagIn), .leakOkIn(leakOkIn),
    .gate1(gate1), .gate2(gate2), .leakTestEn(leakTestEn), .status(status)
  );

  // vector: {ctrl, ch1En, ch2En, leakOk, expGate1, expGate2}
  localparam logic [5:0] VEC [8] = '{
    6'b1111_11, 6'b1101_10, 6'b1011_01, 6'b1110_01,
    6'b0111_00, 6'b1001_00, 6'b1100_00, 6'b0011_00
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    int firstLeak, leakLen, firstOn, firstOff, pulseLen, firstG2, g1During;
    tick(3);
    check("R1 reset gate1", gate1, 0);
    check("R1 reset gate2", gate2, 0);
    check("R2 reset leakTestEn", leakTestEn, 0);
    check("R5 reset status", status, 0);
    rstN = 1'b1;
    tick(2);

    // table walk: R1 / R3 / R8 steady results
    foreach (VEC[i]) begin
      ctrlIn = 1'b0;
      tick(6);
      ch1En = VEC[i][4]; ch2En = VEC[i][3]; leakOkIn = VEC[i][2];
      ctrlIn = VEC[i][5];
      tick(30);
      check($sformatf("R8/R3/R1 vec%0d gate1", i), gate1, VEC[i][1]);
      check($sformatf("R8/R3/R1 vec%0d gate2", i), gate2, VEC[i][0]);
    end

    // R2 / R9 / R3: leakage window timing
    ctrlIn = 1'b0; ch2En = 1'b0; ch1En = 1'b1; leakOkIn = 1'b1;
    tick(6);
    ctrlIn = 1'b1;
    firstLeak = -1; leakLen = 0; firstOn = -1; g1During = 0;
    for (int k = 1; k <= 20; k++) begin
      tick(1);
      if (leakTestEn) begin
        leakLen++;
        if (firstLeak < 0) firstLeak = k;
        if (gate1) g1During++;
      end
      if (gate1 && firstOn < 0) firstOn = k;
    end
    check("R9 first leak-test cycle", firstLeak, 3);
    check("R2 leak-test length", leakLen, LEAK);
    check("R2 gate1 during test", g1During, 0);
    check("R3 gate1 on cycle", firstOn, 3 + LEAK);

    // R4: burst one cycle short of detection
    ocFlagIn = 1'b1;
    tick(OCD - 1);
    ocFlagIn = 1'b0;
    tick(10);
    check("R4 short burst gate1", gate1, 1);
    check("R4 short burst latch", status[0], 0);

    // R4 / R5: sustained over-current
    ocFlagIn = 1'b1;
    firstOff = -1;
    for (int k = 1; k <= 20; k++) begin
      tick(1);
      if (!gate1 && firstOff < 0) firstOff = k;
    end
    check("R4 trip cycle", firstOff, 2 + OCD);
    check("R5 latch status", status[0], 1);
    ocFlagIn = 1'b0;
    tick(20);
    check("R5 stays off with request held", gate1, 0);
    ctrlIn = 1'b0;
    tick(6);
    ctrlIn = 1'b1;
    tick(20);
    check("R5 re-armed gate1", gate1, 1);
    check("R5 latch cleared", status[0], 0);

    // R8: channel 2 added while channel 1 is on
    ch2En = 1'b1;
    tick(2);
    check("R8 gate2 added", gate2, 1);
    check("R8 gate1 undisturbed", gate1, 1);

    // R1: control low turns both off
    ctrlIn = 1'b0;
    tick(3);
    check("R1 gate1 off", gate1, 0);
    check("R1 gate2 off", gate2, 0);
    ch2En = 1'b0;

    // R3: failing leakage test
    leakOkIn = 1'b0;
    tick(4);
    ctrlIn = 1'b1;
    tick(20);
    check("R3 fail gate1", gate1, 0);
    check("R3 fail status", status[1], 1);
    ctrlIn = 1'b0; leakOkIn = 1'b1;
    tick(6);
    check("R3 fail status cleared", status[1], 0);

    // R6: short overvoltage burst
    ovFlagIn = 1'b1;
    tick(OVD - 1);
    ovFlagIn = 1'b0;
    pulseLen = 0;
    for (int k = 1; k <= 20; k++) begin
      tick(1);
      if (gate2) pulseLen++;
    end
    check("R6 short burst no pulse", pulseLen, 0);

    // R6 / R7: qualified overvoltage pulse with control low
    ovFlagIn = 1'b1;
    pulseLen = 0; firstG2 = -1; g1During = 0;
    for (int k = 1; k <= 40; k++) begin
      tick(1);
      if (k == OVD + 4) ovFlagIn = 1'b0;
      if (gate2) begin
        pulseLen++;
        if (firstG2 < 0) firstG2 = k;
        if (!status[2]) g1During++;
      end
      if (gate1) g1During++;
    end
    check("R6 pulse start", firstG2, 2 + OVD);
    check("R6 pulse length", pulseLen, OVA);
    check("R7 gate1 off and status during pulse", g1During, 0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule